// File: doc/BRIEF.md
# Microcode Sequencer with Opcode Dispatch

This block is the control sequencer of a microcoded processor. A micro-program counter selects one word of a sixteen-entry microcode store. The word has two parts. The first is a sixteen-bit control word that drives the datapath during that cycle. The second is a two-bit sequencing code that decides where the counter goes on the next clock edge. There are four choices: return to the fetch word at address 0, step to the following address, or jump through one of two lookup tables indexed by the live 6-bit instruction opcode.

The first table is used in the decode step and fans out to one routine per instruction class. The second is used after the shared address-calculation step and separates loads from stores. If an opcode has no entry in the table being consulted, the sequencer jumps to a trap routine at address 10. In the same cycle it raises `unknown_op` so the surrounding logic can record an illegal instruction. The microcode store and both tables are constants computed inside the RTL.

Top module: `useq_sequencer`

## Requirements
- R1: A high `rst` at a rising clock edge sets `uaddr` to 0. It stays at 0 for as long as `rst` is sampled high, including when reset arrives in the middle of a routine.
- R2: Sequencing code 00 sends the counter to 0 at the next edge. Addresses 4, 5, 7, 8, 9 and 10 carry this code, so each of them is followed by address 0.
- R3: Sequencing code 11 adds one to the counter. Addresses 0, 3 and 6 carry this code, giving the steps 0→1, 3→4 and 6→7.
- R4: Address 1 carries code 01 and uses the first table with the opcode present in that cycle. The mappings are 0x00→6, 0x23→2, 0x2B→2, 0x04→8 and 0x02→9.
- R5: Address 2 carries code 10 and uses the second table. The mappings are 0x23→3 and 0x2B→5.
- R6: An opcode missing from the first table while at address 1 sends the counter to 10. `unknown_op` is high during that cycle.
- R7: An opcode missing from the second table while at address 2 sends the counter to 10. `unknown_op` is high during that cycle.
- R8: `unknown_op` is low in every cycle where the current word does not consult a table. It is also low while reset holds the counter.
- R9: The low six bits of `ctrl` are: bit0 memory read, bit1 memory write, bit2 instruction-register load, bit3 PC write, bit4 register-file write, bit5 conditional PC write. Read as bits 5..0, they equal 001101 at address 0, 000001 at address 3, 010000 at addresses 4 and 7, 000010 at address 5, 100000 at address 8, 001000 at address 9, and 000000 at addresses 1, 2, 6 and 10.
- R10: The opcode is ignored at addresses whose code is 00 or 11. Changing it there does not alter the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction opcode used by the dispatch tables |
| ctrl | output | 16 | Datapath control word of the current micro-address |
| uaddr | output | 4 | Current micro-program counter |
| unknown_op | output | 1 | Current table lookup missed; the next address is the trap routine |

## Verification
The in-RTL properties check the counter transitions on every cycle. They cover return to zero, increment, agreement with the table output, the trap jump after a missed lookup, and reset. They also check that a miss is only ever flagged during a dispatch step. Only the bench's scenarios show that the table contents are right for each instruction class and that each address drives the intended control bits. They also show that an opcode which changes mid-routine steers only the dispatch steps, and that a second-table miss is reached when the opcode changes between decode and address calculation.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UADDR_W = 4;
    localparam int OPC_W   = 6;

    typedef enum logic [1:0] {
        SEQ_RESTART = 2'b00,
        SEQ_TBL_A   = 2'b01,
        SEQ_TBL_B   = 2'b10,
        SEQ_STEP    = 2'b11
    } seq_code_e;

    // Packed MSB first: mem_rd ends up at bit 0.
    typedef struct packed {
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic [1:0] alu_src_b;
        logic       alu_src_a;
        logic       addr_sel;
        logic       mem_to_reg;
        logic       reg_dst;
        logic       pc_wr_cond;
        logic       reg_wr;
        logic       pc_wr;
        logic       ir_wr;
        logic       mem_wr;
        logic       mem_rd;
    } ctrl_word_t;

    localparam int CTRL_W = $bits(ctrl_word_t);

    localparam logic [OPC_W-1:0] OPC_ALU   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;

    localparam logic [UADDR_W-1:0] UA_FETCH  = 4'd0;
    localparam logic [UADDR_W-1:0] UA_MEMADR = 4'd2;
    localparam logic [UADDR_W-1:0] UA_LDRD   = 4'd3;
    localparam logic [UADDR_W-1:0] UA_STWR   = 4'd5;
    localparam logic [UADDR_W-1:0] UA_ALUEX  = 4'd6;
    localparam logic [UADDR_W-1:0] UA_BRANCH = 4'd8;
    localparam logic [UADDR_W-1:0] UA_JUMP   = 4'd9;
    localparam logic [UADDR_W-1:0] UA_TRAP   = 4'd10;

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int AW = UADDR_W
) (
    input  logic [AW-1:0] upc,
    output ctrl_word_t    word,
    output seq_code_e     seq
);

    always_comb begin
        word = '0;
        seq  = SEQ_RESTART;
        case (upc)
            4'd0: begin // fetch
                word.mem_rd    = 1'b1;
                word.ir_wr     = 1'b1;
                word.pc_wr     = 1'b1;
                word.alu_src_b = 2'b01;
                seq            = SEQ_STEP;
            end
            4'd1: begin // decode
                word.alu_src_b = 2'b11;
                seq            = SEQ_TBL_A;
            end
            4'd2: begin // effective address
                word.alu_src_a = 1'b1;
                word.alu_src_b = 2'b10;
                seq            = SEQ_TBL_B;
            end
            4'd3: begin // load read
                word.mem_rd   = 1'b1;
                word.addr_sel = 1'b1;
                seq           = SEQ_STEP;
            end
            4'd4: begin // load writeback
                word.reg_wr     = 1'b1;
                word.mem_to_reg = 1'b1;
            end
            4'd5: begin // store write
                word.mem_wr   = 1'b1;
                word.addr_sel = 1'b1;
            end
            4'd6: begin // ALU execute
                word.alu_src_a = 1'b1;
                word.alu_op    = 2'b10;
                seq            = SEQ_STEP;
            end
            4'd7: begin // ALU writeback
                word.reg_wr  = 1'b1;
                word.reg_dst = 1'b1;
            end
            4'd8: begin // branch compare
                word.alu_src_a  = 1'b1;
                word.alu_op     = 2'b01;
                word.pc_wr_cond = 1'b1;
                word.pc_src     = 2'b01;
            end
            4'd9: begin // jump
                word.pc_wr  = 1'b1;
                word.pc_src = 2'b10;
            end
            default: begin // trap routine and unused words: quiet, restart
                word = '0;
                seq  = SEQ_RESTART;
            end
        endcase
    end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int TABLE_ID = 0,
    parameter int OW       = OPC_W,
    parameter int AW       = UADDR_W
) (
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] target,
    output logic          hit
);

    generate
        if (TABLE_ID == 0) begin : g_decode_tbl
            always_comb begin
                hit    = 1'b1;
                target = UA_TRAP;
                case (opcode)
                    OPC_ALU:   target = UA_ALUEX;
                    OPC_LOAD:  target = UA_MEMADR;
                    OPC_STORE: target = UA_MEMADR;
                    OPC_BEQ:   target = UA_BRANCH;
                    OPC_JMP:   target = UA_JUMP;
                    default:   hit    = 1'b0;
                endcase
            end
        end else begin : g_memop_tbl
            always_comb begin
                hit    = 1'b1;
                target = UA_TRAP;
                case (opcode)
                    OPC_LOAD:  target = UA_LDRD;
                    OPC_STORE: target = UA_STWR;
                    default:   hit    = 1'b0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW = UADDR_W
) (
    input  seq_code_e     seq,
    input  logic [AW-1:0] upc,
    input  logic [AW-1:0] tgt_a,
    input  logic          hit_a,
    input  logic [AW-1:0] tgt_b,
    input  logic          hit_b,
    output logic [AW-1:0] nxt,
    output logic          miss
);

    always_comb begin
        miss = 1'b0;
        case (seq)
            SEQ_RESTART: nxt = '0;
            SEQ_TBL_A: begin
                nxt  = hit_a ? tgt_a : UA_TRAP;
                miss = !hit_a;
            end
            SEQ_TBL_B: begin
                nxt  = hit_b ? tgt_b : UA_TRAP;
                miss = !hit_b;
            end
            default: nxt = AW'(upc + 1'b1);
        endcase
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OPC_W-1:0]    opcode,
    output logic [CTRL_W-1:0]   ctrl,
    output logic [UADDR_W-1:0]  uaddr,
    output logic                unknown_op
);

    typedef struct packed {
        logic [UADDR_W-1:0] upc;
    } seq_state_t;

    seq_state_t st_d, st_q;

    ctrl_word_t         word;
    seq_code_e          seq;
    logic [UADDR_W-1:0] tgt_a, tgt_b, nxt;
    logic               hit_a, hit_b, miss;

    useq_store #(.AW(UADDR_W)) u_store (
        .upc  (st_q.upc),
        .word (word),
        .seq  (seq)
    );

    useq_dispatch #(.TABLE_ID(0), .OW(OPC_W), .AW(UADDR_W)) u_tbl_a (
        .opcode (opcode),
        .target (tgt_a),
        .hit    (hit_a)
    );

    useq_dispatch #(.TABLE_ID(1), .OW(OPC_W), .AW(UADDR_W)) u_tbl_b (
        .opcode (opcode),
        .target (tgt_b),
        .hit    (hit_b)
    );

    useq_next #(.AW(UADDR_W)) u_next (
        .seq   (seq),
        .upc   (st_q.upc),
        .tgt_a (tgt_a),
        .hit_a (hit_a),
        .tgt_b (tgt_b),
        .hit_b (hit_b),
        .nxt   (nxt),
        .miss  (miss)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ctrl       = word;
    assign uaddr      = st_q.upc;
    assign unknown_op = miss;

    // R1
    p_reset_zero_r1: assert property (@(posedge clk) rst |=> uaddr == '0);
    // R2
    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        seq == SEQ_RESTART |=> uaddr == '0);
    // R3
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        seq == SEQ_STEP |=> uaddr == UADDR_W'($past(uaddr) + 1'b1));
    // R4
    p_tbl_a_r4: assert property (@(posedge clk) disable iff (rst)
        (seq == SEQ_TBL_A && hit_a) |=> uaddr == $past(tgt_a));
    // R5
    p_tbl_b_r5: assert property (@(posedge clk) disable iff (rst)
        (seq == SEQ_TBL_B && hit_b) |=> uaddr == $past(tgt_b));
    // R6, R7
    p_trap_r6: assert property (@(posedge clk) disable iff (rst)
        unknown_op |=> uaddr == UA_TRAP);
    // R8
    p_flag_only_dispatch_r8: assert property (@(posedge clk) disable iff (rst)
        unknown_op |-> (seq == SEQ_TBL_A || seq == SEQ_TBL_B));

endmodule

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;
    import useq_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [OPC_W-1:0]    opcode = '0;
    logic [CTRL_W-1:0]   ctrl;
    logic [UADDR_W-1:0]  uaddr;
    logic                unknown_op;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    useq_sequencer dut (
        .clk        (clk),
        .rst        (rst),
        .opcode     (opcode),
        .ctrl       (ctrl),
        .uaddr      (uaddr),
        .unknown_op (unknown_op)
    );

    // {opcode, expected uaddr, expected unknown_op, expected ctrl[5:0]}
    localparam int NV = 33;
    localparam logic [16:0] VEC [NV] = '{
        // ALU class: R3 0->1, R4 0x00->6, R3 6->7, R2 7->0, R9
        {6'h00, 4'd0,  1'b0, 6'b001101},
        {6'h00, 4'd1,  1'b0, 6'b000000},
        {6'h00, 4'd6,  1'b0, 6'b000000},
        {6'h00, 4'd7,  1'b0, 6'b010000},
        // load: R4 0x23->2, R5 0x23->3, R3 3->4, R2 4->0
        {6'h23, 4'd0,  1'b0, 6'b001101},
        {6'h23, 4'd1,  1'b0, 6'b000000},
        {6'h23, 4'd2,  1'b0, 6'b000000},
        {6'h23, 4'd3,  1'b0, 6'b000001},
        {6'h23, 4'd4,  1'b0, 6'b010000},
        // store: R4 0x2B->2, R5 0x2B->5, R2 5->0
        {6'h2B, 4'd0,  1'b0, 6'b001101},
        {6'h2B, 4'd1,  1'b0, 6'b000000},
        {6'h2B, 4'd2,  1'b0, 6'b000000},
        {6'h2B, 4'd5,  1'b0, 6'b000010},
        // branch: R4 0x04->8, R2 8->0, R9
        {6'h04, 4'd0,  1'b0, 6'b001101},
        {6'h04, 4'd1,  1'b0, 6'b000000},
        {6'h04, 4'd8,  1'b0, 6'b100000},
        // jump: R4 0x02->9, R2 9->0
        {6'h02, 4'd0,  1'b0, 6'b001101},
        {6'h02, 4'd1,  1'b0, 6'b000000},
        {6'h02, 4'd9,  1'b0, 6'b001000},
        // R6: unknown opcode at decode, trap then R2 10->0
        {6'h3F, 4'd0,  1'b0, 6'b001101},
        {6'h3F, 4'd1,  1'b1, 6'b000000},
        {6'h3F, 4'd10, 1'b0, 6'b000000},
        // R7: opcode changes to one absent from the second table
        {6'h23, 4'd0,  1'b0, 6'b001101},
        {6'h23, 4'd1,  1'b0, 6'b000000},
        {6'h00, 4'd2,  1'b1, 6'b000000},
        {6'h00, 4'd10, 1'b0, 6'b000000},
        // R10: opcode noise at non-dispatch steps, R8 flag stays low
        {6'h3F, 4'd0,  1'b0, 6'b001101},
        {6'h00, 4'd1,  1'b0, 6'b000000},
        {6'h3F, 4'd6,  1'b0, 6'b000000},
        {6'h11, 4'd7,  1'b0, 6'b010000},
        {6'h3F, 4'd0,  1'b0, 6'b001101},
        {6'h02, 4'd1,  1'b0, 6'b000000},
        {6'h3F, 4'd9,  1'b0, 6'b001000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // reset state: R1, R8
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset uaddr", 16'(uaddr), 16'd0);
        check("R8 reset flag", 16'(unknown_op), 16'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            opcode = VEC[i][16:11];
            #1;
            check($sformatf("R2-path uaddr vec%0d (R3 R4 R5 R6 R7 R10)", i), 16'(uaddr), 16'(VEC[i][10:7]));
            check($sformatf("R8 flag vec%0d", i), 16'(unknown_op), 16'(VEC[i][6]));
            check($sformatf("R9 ctrl vec%0d", i), 16'(ctrl[5:0]), 16'(VEC[i][5:0]));
            @(negedge clk);
        end
        // last vector was address 9: next must be 0 (R2)
        #1;
        check("R2 jump returns", 16'(uaddr), 16'd0);

        // R1: reset in the middle of a routine
        opcode = OPC_ALU;
        @(negedge clk); // at 1
        @(negedge clk); // at 6
        #1;
        check("R4 reach exec", 16'(uaddr), 16'd6);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-routine reset", 16'(uaddr), 16'd0);
        @(negedge clk);
        check("R1 held reset", 16'(uaddr), 16'd0);
        opcode = 6'h3F;
        @(negedge clk);
        check("R1 held reset opcode", 16'(uaddr), 16'd0);
        check("R8 flag in reset", 16'(unknown_op), 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R3 step after reset", 16'(uaddr), 16'd1);
        check("R6 flag at decode", 16'(unknown_op), 16'd1);
        @(negedge clk);
        check("R6 trap address", 16'(uaddr), 16'd10);
        check("R9 trap quiet", 16'(ctrl[5:0]), 16'd0);
        summary();
    end

endmodule